// File: doc/BRIEF.md
# Chained-Descriptor Block Copy Engine

This block is a single-channel copy engine. It moves blocks of 32-bit words from one memory region to another without the processor touching each word. Software describes the work as a linked chain of four-word descriptors in memory. It writes the address of the first descriptor into a register, waits until the status register shows the channel idle, and then sets the start bit. The engine reads each descriptor, copies its block through a small internal FIFO, and hands the descriptor back to software by clearing its ownership flag. It then follows the link to the next descriptor, if there is one. When the chain ends, or when a descriptor is not usable, the engine raises a sticky interrupt.

All addresses on the memory port are word addresses. The engine has one memory port. A request is accepted in a cycle in which both `mem_req` and `mem_gnt` are high. A read returns its data with `mem_rvalid` one or more cycles after acceptance, and responses come back in order. The engine never has more than one read outstanding.

A descriptor occupies four consecutive words:
- word +0: source address.
- word +1: destination address.
- word +2: control word. Bit 31 is valid. Bit 30 is owner, where 1 means the engine owns it. Bit 29 is has-next. Bits 15:0 are the length in words.
- word +3: address of the next descriptor.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset, the status register reads 0, `irq_o` is low and `mem_req` is low.
- R2: Writing CSR address 1 with bit 0 set while the channel is idle starts a chain. The engine reads the descriptor words at base+0 to base+3, where base is the value held at CSR address 0.
- R3: A start write while the channel is busy has no effect. The running chain continues unchanged, and no descriptor is fetched from the newly written base.
- R4: For a descriptor with length N, destination word i receives source word i for every i below N, and no other destination word is written. A length of 0 moves no data.
- R5: After a block has been written, the engine writes the control word back to descriptor word +2 with bit 30 cleared and every other bit unchanged.
- R6: When bit 29 of the control word is set, the engine next processes the descriptor at the address held in word +3. When bit 29 is clear, the chain ends.
- R7: A descriptor fetched with bit 31 or bit 30 clear stops the chain. It moves no data, gets no write-back, and sets the error bit (status bit 2) and the interrupt bit.
- R8: The interrupt bit (status bit 1) and `irq_o` are set when a chain ends. They stay set until a write to CSR address 2 with bit 1 set. The error bit is cleared the same way through bit 2.
- R9: Data passes through a 16-word FIFO. The order of the words is kept for blocks longer than the FIFO, including when the memory withholds grant.
- R10: Status bit 0 (busy) is high from the start of a chain until it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register index: 0 base, 1 start, 2 status |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for `csr_addr` |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Word address of the request |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| irq_o | output | 1 | Sticky interrupt |

## Verification
The hardest case to reach from the ports is a start write that lands while a chain is in the middle of copying. This matters most when the FIFO is partly full and the memory is stalling grant. The bench starts a 30-word copy under a grant pattern that withholds acceptance on some cycles. A few cycles later it rewrites the base register to point at a second descriptor and pulses start. It then checks that the second descriptor was never fetched, that its destination stays untouched, and that its owner bit stays set. A sweep over lengths 0 to 24, plus a 40-word block, under both grant patterns covers the length-0 case and FIFO wrap.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int CW_VALID = 31;
  localparam int CW_OWNER = 30;
  localparam int CW_LINK  = 29;

  localparam logic [1:0] CSR_BASE  = 2'd0;
  localparam logic [1:0] CSR_START = 2'd1;
  localparam logic [1:0] CSR_STAT  = 2'd2;

  localparam int SB_BUSY = 0;
  localparam int SB_IRQ  = 1;
  localparam int SB_ERR  = 2;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DREQ  = 3'd1,
    ST_DWAIT = 3'd2,
    ST_COPY  = 3'd3,
    ST_WBACK = 3'd4
  } chain_state_e;
endpackage

// File: rtl/dma_word_fifo.sv
module dma_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [W-1:0]     store_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push) wptr_d = (wptr_q == PTR_W'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
    if (pop)  rptr_d = (rptr_q == PTR_W'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store_q[wptr_q] <= wdata;
  end

  assign rdata = store_q[rptr_q];
  assign count = cnt_q;

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (cnt_q != CNT_W'(DEPTH))); // R9
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0)); // R9
endmodule

// File: rtl/dma_chain_regs.sv
module dma_chain_regs
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [1:0]        csr_addr,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  input  logic              busy,
  input  logic              done_pulse,
  input  logic              err_pulse,
  output logic              start,
  output logic [ADDR_W-1:0] desc_base,
  output logic              irq_o
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic              irq_q, irq_d, err_q, err_d;
  logic              wr_base, wr_stat, clr_irq, clr_err;

  always_comb begin
    wr_base = csr_we && (csr_addr == CSR_BASE);
    wr_stat = csr_we && (csr_addr == CSR_STAT);
    clr_irq = wr_stat && csr_wdata[SB_IRQ];
    clr_err = wr_stat && csr_wdata[SB_ERR];
    start   = csr_we && (csr_addr == CSR_START) && csr_wdata[0] && !busy;
    base_d  = wr_base ? csr_wdata[ADDR_W-1:0] : base_q;
    irq_d   = (done_pulse || err_pulse) ? 1'b1 : (clr_irq ? 1'b0 : irq_q);
    err_d   = err_pulse ? 1'b1 : (clr_err ? 1'b0 : err_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      irq_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      irq_q  <= irq_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    csr_rdata = '0;
    case (csr_addr)
      CSR_BASE: csr_rdata = DATA_W'(base_q);
      CSR_STAT: begin
        csr_rdata[SB_BUSY] = busy;
        csr_rdata[SB_IRQ]  = irq_q;
        csr_rdata[SB_ERR]  = err_q;
      end
      default: csr_rdata = '0;
    endcase
  end

  assign desc_base = base_q;
  assign irq_o     = irq_q;

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !clr_irq) |=> irq_q); // R8
  AST_ERR_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> (irq_q && err_q)); // R7
endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 16,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic [ADDR_W-1:0]               desc_base,
  output logic                            busy,
  output logic                            done_pulse,
  output logic                            err_pulse,
  output logic                            mem_req,
  output logic                            mem_we,
  output logic [ADDR_W-1:0]               mem_addr,
  output logic [DATA_W-1:0]               mem_wdata,
  input  logic                            mem_gnt,
  input  logic                            mem_rvalid,
  input  logic [DATA_W-1:0]               mem_rdata,
  output logic                            fifo_push,
  output logic                            fifo_pop,
  input  logic [DATA_W-1:0]               fifo_rdata,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_count
);
  localparam int CNT_W = $clog2(FIFO_DEPTH+1);

  chain_state_e      st_q, st_d;
  logic [1:0]        idx_q, idx_d;
  logic [ADDR_W-1:0] dptr_q, dptr_d, src_q, src_d, dst_q, dst_d, nxt_q, nxt_d;
  logic [DATA_W-1:0] ctl_q, ctl_d;
  logic [LEN_W-1:0]  rcnt_q, rcnt_d, wcnt_q, wcnt_d, len;
  logic              pend_q, pend_d;
  logic              desc_ok;

  assign len     = ctl_q[LEN_W-1:0];
  assign desc_ok = mem_rdata[CW_VALID] && mem_rdata[CW_OWNER];

  always_comb begin
    st_d       = st_q;
    idx_d      = idx_q;
    dptr_d     = dptr_q;
    src_d      = src_q;
    dst_d      = dst_q;
    nxt_d      = nxt_q;
    ctl_d      = ctl_q;
    rcnt_d     = rcnt_q;
    wcnt_d     = wcnt_q;
    pend_d     = pend_q;
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = '0;
    mem_wdata  = '0;
    fifo_push  = 1'b0;
    fifo_pop   = 1'b0;
    done_pulse = 1'b0;
    err_pulse  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          dptr_d = desc_base;
          idx_d  = '0;
          st_d   = ST_DREQ;
        end
      end
      ST_DREQ: begin
        mem_req  = 1'b1;
        mem_addr = dptr_q + ADDR_W'(idx_q);
        if (mem_gnt) st_d = ST_DWAIT;
      end
      ST_DWAIT: begin
        if (mem_rvalid) begin
          case (idx_q)
            2'd0:    src_d = mem_rdata[ADDR_W-1:0];
            2'd1:    dst_d = mem_rdata[ADDR_W-1:0];
            2'd2:    ctl_d = mem_rdata;
            default: nxt_d = mem_rdata[ADDR_W-1:0];
          endcase
          if (idx_q == 2'd2 && !desc_ok) begin
            err_pulse = 1'b1;
            st_d      = ST_IDLE;
          end else if (idx_q == 2'd3) begin
            rcnt_d = '0;
            wcnt_d = '0;
            pend_d = 1'b0;
            st_d   = ST_COPY;
          end else begin
            idx_d = idx_q + 1'b1;
            st_d  = ST_DREQ;
          end
        end
      end
      ST_COPY: begin
        if (pend_q && mem_rvalid) begin
          fifo_push = 1'b1;
          pend_d    = 1'b0;
        end
        if (wcnt_q == len && !pend_q) begin
          st_d = ST_WBACK;
        end else if (!pend_q && rcnt_q != len && fifo_count != CNT_W'(FIFO_DEPTH)) begin
          mem_req  = 1'b1;
          mem_addr = src_q + ADDR_W'(rcnt_q);
          if (mem_gnt) begin
            pend_d = 1'b1;
            rcnt_d = rcnt_q + 1'b1;
          end
        end else if (fifo_count != '0) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = dst_q + ADDR_W'(wcnt_q);
          mem_wdata = fifo_rdata;
          if (mem_gnt) begin
            fifo_pop = 1'b1;
            wcnt_d   = wcnt_q + 1'b1;
          end
        end
      end
      ST_WBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dptr_q + ADDR_W'(2);
        mem_wdata = ctl_q;
        mem_wdata[CW_OWNER] = 1'b0;
        if (mem_gnt) begin
          if (ctl_q[CW_LINK]) begin
            dptr_d = nxt_q;
            idx_d  = '0;
            st_d   = ST_DREQ;
          end else begin
            done_pulse = 1'b1;
            st_d       = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      dptr_q <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      nxt_q  <= '0;
      ctl_q  <= '0;
      rcnt_q <= '0;
      wcnt_q <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      dptr_q <= dptr_d;
      src_q  <= src_d;
      dst_q  <= dst_d;
      nxt_q  <= nxt_d;
      ctl_q  <= ctl_d;
      rcnt_q <= rcnt_d;
      wcnt_q <= wcnt_d;
      pend_q <= pend_d;
    end
  end

  assign busy = (st_q != ST_IDLE);

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (st_q == ST_IDLE)); // R3
  AST_READ_WITHIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_COPY && mem_req && !mem_we) |-> (rcnt_q < len)); // R4
  AST_WRITE_WITHIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_COPY && mem_req && mem_we) |-> (wcnt_q < rcnt_q)); // R4
  AST_WBACK_OWNED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WBACK) |-> (ctl_q[CW_VALID] && ctl_q[CW_OWNER])); // R7
  AST_CHAIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy)) |-> $past(start)); // R10
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 16,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [1:0]        csr_addr,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              irq_o
);
  localparam int CNT_W = $clog2(FIFO_DEPTH+1);

  logic              busy, done_pulse, err_pulse, start;
  logic [ADDR_W-1:0] desc_base;
  logic              fifo_push, fifo_pop;
  logic [DATA_W-1:0] fifo_rdata;
  logic [CNT_W-1:0]  fifo_count;

  dma_chain_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
    .clk(clk), .rst_n(rst_n),
    .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .busy(busy), .done_pulse(done_pulse), .err_pulse(err_pulse),
    .start(start), .desc_base(desc_base), .irq_o(irq_o)
  );

  dma_chain_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .FIFO_DEPTH(FIFO_DEPTH)) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start(start), .desc_base(desc_base), .busy(busy),
    .done_pulse(done_pulse), .err_pulse(err_pulse),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .fifo_push(fifo_push), .fifo_pop(fifo_pop),
    .fifo_rdata(fifo_rdata), .fifo_count(fifo_count)
  );

  dma_word_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(fifo_push), .wdata(mem_rdata),
    .pop(fifo_pop), .rdata(fifo_rdata), .count(fifo_count)
  );

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R1
endmodule

// File: tb/test_dma_chain_engine.sv
module test_dma_chain_engine;
  logic        clk, rst_n;
  logic        csr_we;
  logic [1:0]  csr_addr;
  logic [31:0] csr_wdata, csr_rdata;
  logic        mem_req, mem_we, mem_gnt, mem_rvalid, irq_o;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int gmode  = 0;
  int fetch_cnt [256];

  logic [31:0] mem [256];
  logic        pend;
  logic [7:0]  paddr;

  localparam logic [31:0] V = 32'h8000_0000;
  localparam logic [31:0] O = 32'h4000_0000;
  localparam logic [31:0] L = 32'h2000_0000;

  dma_chain_engine i_dma_chain_engine (
    .clk(clk), .rst_n(rst_n),
    .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // memory model: decides grant and responds at the falling edge
  initial begin
    pend = 1'b0; paddr = '0; mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = pend;
      mem_rdata  = pend ? mem[paddr] : 32'h0;
      mem_gnt    = (gmode == 0) ? 1'b1 : ((cyc % 3) != 1);
      pend       = 1'b0;
      if (rst_n && mem_req && mem_gnt) begin
        if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
        else begin
          pend  = 1'b1;
          paddr = mem_addr[7:0];
          fetch_cnt[mem_addr[7:0]] = fetch_cnt[mem_addr[7:0]] + 1;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_addr = a;
    #1 d = csr_rdata;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) begin
      mem[i] = 32'hDEAD_0000 | i;
      fetch_cnt[i] = 0;
    end
  endtask

  task automatic put_desc(input int at, input int s, input int d, input logic [31:0] ctl, input int nx);
    mem[at] = s; mem[at+1] = d; mem[at+2] = ctl; mem[at+3] = nx;
  endtask

  task automatic run_and_wait(input int base, input string req);
    int n;
    csr_wr(2'd0, base);
    csr_wr(2'd1, 32'h1);
    n = 0;
    while (!irq_o && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(req, {31'b0, irq_o}, 32'h1);
  endtask

  task automatic clear_status();
    csr_wr(2'd2, 32'h6);
  endtask

  initial begin
    logic [31:0] r;
    csr_we = 1'b0; csr_addr = '0; csr_wdata = '0;
    rst_n = 1'b0;
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    csr_rd(2'd2, r);
    chk("R1 status", r, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    chk("R1 req", {31'b0, mem_req}, 32'h0);

    // R4 R5 R9 sweep of single-descriptor lengths under two grant patterns
    for (int m = 0; m < 2; m++) begin
      gmode = m;
      for (int len = 0; len <= 25; len++) begin
        int ln;
        ln = (len == 25) ? 40 : len;
        clear_mem();
        for (int i = 0; i < 48; i++) mem[64+i] = 32'hA500_0000 | (m << 16) | (ln << 8) | i;
        put_desc(0, 64, 160, V | O | ln, 0);
        run_and_wait(0, "R2 chain completes");
        for (int i = 0; i <= ln; i++) begin
          if (i < ln) chk("R4 R9 copied word", mem[160+i], 32'hA500_0000 | (m << 16) | (ln << 8) | i);
          else        chk("R4 word past end untouched", mem[160+i], 32'hDEAD_0000 | (160+i));
        end
        chk("R5 write-back", mem[2], V | ln);
        chk("R2 each descriptor word fetched once", fetch_cnt[0] + fetch_cnt[1] + fetch_cnt[2] + fetch_cnt[3], 4);
        csr_rd(2'd2, r);
        chk("R10 idle with irq after chain", r, 32'h2);
        clear_status();
        csr_rd(2'd2, r);
        chk("R8 irq cleared by W1C", {r[31:1], irq_o}, 32'h0);
      end
    end

    // R6 three-descriptor chain
    gmode = 1;
    clear_mem();
    for (int i = 0; i < 20; i++) mem[64+i] = 32'hC000_0000 | i;
    put_desc(0,  64, 160, V | O | L | 5, 8);
    put_desc(8,  70, 170, V | O | L | 0, 16);
    put_desc(16, 72, 180, V | O | 7, 0);
    run_and_wait(0, "R6 chain completes");
    for (int i = 0; i < 5; i++) chk("R6 first block", mem[160+i], 32'hC000_0000 | i);
    chk("R6 zero-length block writes nothing", mem[170], 32'hDEAD_0000 | 170);
    for (int i = 0; i < 7; i++) chk("R6 third block", mem[180+i], 32'hC000_0000 | (8+i));
    chk("R6 R5 wb0", mem[2],  V | L | 5);
    chk("R6 R5 wb1", mem[10], V | L | 0);
    chk("R6 R5 wb2", mem[18], V | 7);
    clear_status();

    // R3 R10 start while busy is ignored
    clear_mem();
    for (int i = 0; i < 32; i++) mem[64+i] = 32'hB000_0000 | i;
    put_desc(0,  64, 160, V | O | 30, 0);
    put_desc(24, 64, 220, V | O | 4, 0);
    csr_wr(2'd0, 0);
    csr_wr(2'd1, 32'h1);
    repeat (6) @(negedge clk);
    csr_rd(2'd2, r);
    chk("R10 busy mid-chain", r, 32'h1);
    csr_wr(2'd0, 24);
    csr_wr(2'd1, 32'h1);
    begin
      int n;
      n = 0;
      while (!irq_o && n < 5000) begin @(negedge clk); n++; end
    end
    chk("R3 first chain finished", {31'b0, irq_o}, 32'h1);
    chk("R3 second desc not fetched", fetch_cnt[24] + fetch_cnt[26], 0);
    chk("R3 second dst untouched", mem[220], 32'hDEAD_0000 | 220);
    chk("R3 second desc still owned", mem[26], V | O | 4);
    chk("R3 first chain last word", mem[189], 32'hB000_001D);
    clear_status();

    // R7 invalid descriptor, then not-owned descriptor
    for (int k = 0; k < 2; k++) begin
      clear_mem();
      put_desc(0, 64, 160, (k == 0) ? (O | 4) : (V | 4), 0);
      run_and_wait(0, "R7 error raises irq");
      csr_rd(2'd2, r);
      chk("R7 error and irq bits", r, 32'h6);
      chk("R7 no data moved", mem[160], 32'hDEAD_0000 | 160);
      chk("R7 no write-back", mem[2], (k == 0) ? (O | 4) : (V | 4));
      csr_wr(2'd2, 32'h4);
      csr_rd(2'd2, r);
      chk("R8 err cleared alone, irq kept", r, 32'h2);
      csr_wr(2'd2, 32'h2);
      csr_rd(2'd2, r);
      chk("R8 irq cleared", r, 32'h0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule